// File: doc/BRIEF.md
# Synthesizer Control-Word Loader

This block sits in front of a frequency synthesizer's divider chain. It builds the control word that sets the dividers. The word holds a prescaler enable, a 9-bit main divide value M, a 6-bit reference divide value R and a 4-bit swallow value A. The block also holds a separate 8-bit auxiliary register. Three loading styles are available, chosen by two static configuration pins:

- **Serial:** a bit stream with its own clock and an active-low load window.
- **Parallel:** an 8-bit bus with one write strobe per field group.
- **Direct:** the divider values come straight from dedicated pins.

Serial and parallel writes land in a staging word. A staging-to-active copy moves the whole word into an active word at once, so that a frequency hop takes effect in a single step. A per-mode select decides whether the dividers follow the staging word or the active word.

Every strobe, the serial clock, the serial data and the bus pass through a two-flop synchronizer into the system clock domain. Edges are detected after synchronization. The divider outputs are registered.

Top module: `synth_prog_frontend`

## Requirements
- R1: With `bmode`=1 (direct mode), the divider outputs take `dir_pre_n`, `dir_m`, `dir_r` and `dir_a`, whatever any strobe does.
- R2: With `bmode`=0 and `smode`=1 (serial mode), each synchronized rising edge of `sclk` shifts `sdata` into the staging word from the LSB end, so the first bit received ends at the MSB. This happens only while `load_n` is low. The staging word layout is: bit 19 prescaler enable, bits 18:10 M, bits 9:4 R, bits 3:0 A.
- R3: In serial mode, while `aux_wr` is high, shifted bits go into the 8-bit auxiliary register in the same order, and the staging word is left unchanged.
- R4: In serial mode, a rising edge of `load_n` copies the whole staging word into the active word.
- R5: In parallel mode (`bmode`=0, `smode`=0), a rising edge of `m1_wr` writes `pbus[7]` to the prescaler enable and `pbus[6:0]` to M[6:0].
- R6: In parallel mode, a rising edge of `m2_wr` writes `pbus[3:2]` to R[5:4] and `pbus[1:0]` to M[8:7]. No other field changes.
- R7: In parallel mode, a rising edge of `a_wr` writes `pbus[7:4]` to R[3:0] and `pbus[3:0]` to A[3:0].
- R8: In parallel mode, a rising edge of `aux_wr` writes `pbus[7:0]` into the auxiliary register.
- R9: In serial mode, `fsel_ser`=1 drives the dividers from the staging word and 0 from the active word. In parallel mode, `fsel_par` does the same.
- R10: In serial or parallel mode, a rising edge of `hop_wr` copies the staging word to the active word. If a field write happens in the same cycle, the active word receives the staging word as it stood before that write.
- R11: Parallel strobes change nothing in serial mode. Serial clock edges change nothing in parallel mode.
- R12: Reset clears the staging, active and auxiliary registers and all divider outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bmode | input | 1 | 1 selects direct mode |
| smode | input | 1 | With bmode=0: 1 serial, 0 parallel |
| sdata | input | 1 | Serial data bit |
| sclk | input | 1 | Serial shift clock |
| load_n | input | 1 | Serial load window (low = shifting); rising edge copies staging to active |
| aux_wr | input | 1 | Serial: steers bits to auxiliary register; parallel: auxiliary write strobe |
| fsel_ser | input | 1 | Serial-mode source select (1 staging, 0 active) |
| fsel_par | input | 1 | Parallel-mode source select (1 staging, 0 active) |
| pbus | input | 8 | Parallel data bus |
| m1_wr | input | 1 | Strobe: prescaler enable and M low bits |
| m2_wr | input | 1 | Strobe: R high bits and M high bits |
| a_wr | input | 1 | Strobe: R low bits and A |
| hop_wr | input | 1 | Strobe: staging-to-active copy |
| dir_pre_n | input | 1 | Direct-mode prescaler enable |
| dir_m | input | 9 | Direct-mode M value |
| dir_r | input | 6 | Direct-mode R value |
| dir_a | input | 4 | Direct-mode A value |
| presc_en_n | output | 1 | Prescaler enable, active low (1 bypasses the prescaler) |
| m_val | output | 9 | M divider value |
| r_val | output | 6 | R divider value |
| a_val | output | 4 | A divider value |
| aux_val | output | 8 | Auxiliary register contents |

## Verification
A staging-to-active copy and a write into the staging word can fall in the same system cycle. The bench provokes this by raising `hop_wr` and `a_wr` on the same clock edge, so both strobes leave the synchronizer together. It then reads the active word with `fsel_par`=0 and expects the staging value from before the A-field write. With `fsel_par`=1 it expects the staging word to hold the new byte.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  parameter int M_W   = 9;
  parameter int R_W   = 6;
  parameter int A_W   = 4;
  parameter int E_W   = 8;
  parameter int BUS_W = 8;

  localparam int WORD_W  = 1 + M_W + R_W + A_W;
  localparam int A_LSB   = 0;
  localparam int R_LSB   = A_W;
  localparam int M_LSB   = A_W + R_W;
  localparam int PRE_BIT = WORD_W - 1;
  // parallel field splits
  localparam int M_LO    = BUS_W - 1;
  localparam int M_HI    = M_W - M_LO;
  localparam int R_LO    = BUS_W - A_W;
  localparam int R_HI    = R_W - R_LO;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(input logic b, input logic s);
    if (b)      return MODE_DIR;
    else if (s) return MODE_SER;
    else        return MODE_PAR;
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int N    = 4,
  parameter bit EDGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  logic [N-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  generate
    if (EDGE) begin : g_edge
      logic [N-1:0] s3;
      always_ff @(posedge clk) begin
        if (rst) s3 <= '0;
        else     s3 <= s2;
      end
      assign q = s2 & ~s3;
    end else begin : g_level
      assign q = s2;
    end
  endgenerate
endmodule

// File: rtl/sfe_word_regs.sv
module sfe_word_regs
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode,
  input  logic              sclk_rise,
  input  logic              load_rise,
  input  logic              aux_rise,
  input  logic              m1_rise,
  input  logic              m2_rise,
  input  logic              a_rise,
  input  logic              hop_rise,
  input  logic              load_n_lvl,
  input  logic              aux_lvl,
  input  logic              sdata_lvl,
  input  logic [BUS_W-1:0]  bus_lvl,
  output logic [WORD_W-1:0] prim_q,
  output logic [WORD_W-1:0] sec_q,
  output logic [E_W-1:0]    aux_q
);
  logic              shift_en, par_en, xfer;
  logic [WORD_W-1:0] prim_nxt;
  logic [E_W-1:0]    aux_nxt;

  always_comb begin
    shift_en = (mode == MODE_SER) && sclk_rise && !load_n_lvl;
    par_en   = (mode == MODE_PAR);
    xfer     = ((mode != MODE_DIR) && hop_rise) ||
               ((mode == MODE_SER) && load_rise);
    prim_nxt = prim_q;
    aux_nxt  = aux_q;
    if (shift_en) begin
      if (aux_lvl) aux_nxt  = {aux_q[E_W-2:0], sdata_lvl};
      else         prim_nxt = {prim_q[WORD_W-2:0], sdata_lvl};
    end
    if (par_en) begin
      if (m1_rise) begin
        prim_nxt[PRE_BIT]          = bus_lvl[BUS_W-1];
        prim_nxt[M_LSB +: M_LO]    = bus_lvl[M_LO-1:0];
      end
      if (m2_rise) begin
        prim_nxt[M_LSB+M_LO +: M_HI] = bus_lvl[M_HI-1:0];
        prim_nxt[R_LSB+R_LO +: R_HI] = bus_lvl[M_HI +: R_HI];
      end
      if (a_rise) begin
        prim_nxt[R_LSB +: R_LO] = bus_lvl[A_W +: R_LO];
        prim_nxt[A_LSB +: A_W]  = bus_lvl[A_W-1:0];
      end
      if (aux_rise) aux_nxt = bus_lvl[E_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= '0;
      sec_q  <= '0;
      aux_q  <= '0;
    end else begin
      prim_q <= prim_nxt;
      aux_q  <= aux_nxt;
      if (xfer) sec_q <= prim_q;
    end
  end
endmodule

// File: rtl/sfe_out_sel.sv
module sfe_out_sel
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode,
  input  logic              fsel_ser,
  input  logic              fsel_par,
  input  logic [WORD_W-1:0] prim_q,
  input  logic [WORD_W-1:0] sec_q,
  input  logic              dir_pre_n,
  input  logic [M_W-1:0]    dir_m,
  input  logic [R_W-1:0]    dir_r,
  input  logic [A_W-1:0]    dir_a,
  output logic              presc_en_n,
  output logic [M_W-1:0]    m_val,
  output logic [R_W-1:0]    r_val,
  output logic [A_W-1:0]    a_val
);
  logic [WORD_W-1:0] src;

  always_comb begin
    unique case (mode)
      MODE_DIR: src = {dir_pre_n, dir_m, dir_r, dir_a};
      MODE_SER: src = fsel_ser ? prim_q : sec_q;
      default:  src = fsel_par ? prim_q : sec_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_en_n <= 1'b0;
      m_val      <= '0;
      r_val      <= '0;
      a_val      <= '0;
    end else begin
      presc_en_n <= src[PRE_BIT];
      m_val      <= src[M_LSB +: M_W];
      r_val      <= src[R_LSB +: R_W];
      a_val      <= src[A_LSB +: A_W];
    end
  end
endmodule

// File: rtl/synth_prog_frontend.sv
module synth_prog_frontend
  import sfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bmode,
  input  logic             smode,
  input  logic             sdata,
  input  logic             sclk,
  input  logic             load_n,
  input  logic             aux_wr,
  input  logic             fsel_ser,
  input  logic             fsel_par,
  input  logic [BUS_W-1:0] pbus,
  input  logic             m1_wr,
  input  logic             m2_wr,
  input  logic             a_wr,
  input  logic             hop_wr,
  input  logic             dir_pre_n,
  input  logic [M_W-1:0]   dir_m,
  input  logic [R_W-1:0]   dir_r,
  input  logic [A_W-1:0]   dir_a,
  output logic             presc_en_n,
  output logic [M_W-1:0]   m_val,
  output logic [R_W-1:0]   r_val,
  output logic [A_W-1:0]   a_val,
  output logic [E_W-1:0]   aux_val
);
  localparam int NE = 7;
  localparam int NL = BUS_W + 3;

  mode_e             mode;
  logic [NE-1:0]     edges;
  logic [NL-1:0]     levels;
  logic [WORD_W-1:0] prim_q, sec_q;
  logic [E_W-1:0]    aux_q;

  assign mode = decode_mode(bmode, smode);

  sfe_sync #(.N(NE), .EDGE(1'b1)) u_edge_sync (
    .clk (clk),
    .rst (rst),
    .din ({hop_wr, a_wr, m2_wr, m1_wr, aux_wr, load_n, sclk}),
    .q   (edges)
  );

  sfe_sync #(.N(NL), .EDGE(1'b0)) u_level_sync (
    .clk (clk),
    .rst (rst),
    .din ({pbus, sdata, aux_wr, load_n}),
    .q   (levels)
  );

  sfe_word_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .sclk_rise  (edges[0]),
    .load_rise  (edges[1]),
    .aux_rise   (edges[2]),
    .m1_rise    (edges[3]),
    .m2_rise    (edges[4]),
    .a_rise     (edges[5]),
    .hop_rise   (edges[6]),
    .load_n_lvl (levels[0]),
    .aux_lvl    (levels[1]),
    .sdata_lvl  (levels[2]),
    .bus_lvl    (levels[3 +: BUS_W]),
    .prim_q     (prim_q),
    .sec_q      (sec_q),
    .aux_q      (aux_q)
  );

  sfe_out_sel u_out (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .fsel_ser   (fsel_ser),
    .fsel_par   (fsel_par),
    .prim_q     (prim_q),
    .sec_q      (sec_q),
    .dir_pre_n  (dir_pre_n),
    .dir_m      (dir_m),
    .dir_r      (dir_r),
    .dir_a      (dir_a),
    .presc_en_n (presc_en_n),
    .m_val      (m_val),
    .r_val      (r_val),
    .a_val      (a_val)
  );

  assign aux_val = aux_q;
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker
  import sfe_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bmode,
  input logic              smode,
  input logic              fsel_ser,
  input logic              dir_pre_n,
  input logic [M_W-1:0]    dir_m,
  input logic [R_W-1:0]    dir_r,
  input logic [A_W-1:0]    dir_a,
  input logic              presc_en_n,
  input logic [M_W-1:0]    m_val,
  input logic [R_W-1:0]    r_val,
  input logic [A_W-1:0]    a_val,
  input logic [WORD_W-1:0] prim_q,
  input logic [WORD_W-1:0] sec_q,
  input logic [E_W-1:0]    aux_q
);
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bmode)) |->
      ({presc_en_n, m_val, r_val, a_val} == $past({dir_pre_n, dir_m, dir_r, dir_a}))); // R1

  AST_SER_SHIFT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (prim_q != $past(prim_q) && !$past(bmode) && $past(smode)) |->
      (prim_q[WORD_W-1:1] == $past(prim_q[WORD_W-2:0]))); // R2

  AST_AUX_SHIFT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (aux_q != $past(aux_q) && !$past(bmode) && $past(smode)) |->
      (aux_q[E_W-1:1] == $past(aux_q[E_W-2:0]))); // R11

  AST_ACTIVE_COPY: assert property (@(posedge clk) disable iff (rst)
    (sec_q != $past(sec_q)) |-> (sec_q == $past(prim_q))); // R10

  AST_SER_ACTIVE_SRC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bmode) && $past(smode) && !$past(fsel_ser)) |->
      ({presc_en_n, m_val, r_val, a_val} == $past(sec_q))); // R9
endmodule

bind synth_prog_frontend sfe_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .bmode      (bmode),
  .smode      (smode),
  .fsel_ser   (fsel_ser),
  .dir_pre_n  (dir_pre_n),
  .dir_m      (dir_m),
  .dir_r      (dir_r),
  .dir_a      (dir_a),
  .presc_en_n (presc_en_n),
  .m_val      (m_val),
  .r_val      (r_val),
  .a_val      (a_val),
  .prim_q     (prim_q),
  .sec_q      (sec_q),
  .aux_q      (aux_q)
);

// File: tb/synth_prog_frontend_test.sv
`timescale 1ns/1ps
module synth_prog_frontend_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, bmode, smode, sdata, sclk, load_n, aux_wr, fsel_ser, fsel_par;
  logic [7:0] pbus;
  logic m1_wr, m2_wr, a_wr, hop_wr, dir_pre_n;
  logic [8:0] dir_m;
  logic [5:0] dir_r;
  logic [3:0] dir_a;
  logic presc_en_n;
  logic [8:0] m_val;
  logic [5:0] r_val;
  logic [3:0] a_val;
  logic [7:0] aux_val;

  synth_prog_frontend uut (.*);

  typedef struct {
    logic [19:0] word;
    logic [7:0]  aux;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [19:0] m_prim = '0, m_sec = '0;
  logic [7:0]  m_aux = '0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    if (bmode) e.word = {dir_pre_n, dir_m, dir_r, dir_a};
    else if (smode) e.word = fsel_ser ? m_prim : m_sec;
    else e.word = fsel_par ? m_prim : m_sec;
    e.aux = m_aux;
    e.tag = tag;
    q.push_back(e);
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: settles past synchronizer and output register, then compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        cyc(8);
        checks++;
        if ({presc_en_n, m_val, r_val, a_val} !== q[0].word) begin
          errors++;
          $display("FAIL %s word actual=%h expected=%h", q[0].tag,
                   {presc_en_n, m_val, r_val, a_val}, q[0].word);
        end
        checks++;
        if (aux_val !== q[0].aux) begin
          errors++;
          $display("FAIL %s aux actual=%h expected=%h", q[0].tag, aux_val, q[0].aux);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic shift_bits(input logic [19:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      cyc(3);
      sclk = 1'b1;
      cyc(3);
      sclk = 1'b0;
    end
    cyc(2);
  endtask

  task automatic pstrobe(input int which, input logic [7:0] d);
    pbus = d;
    cyc(4);
    case (which)
      1: m1_wr = 1'b1;
      2: m2_wr = 1'b1;
      3: a_wr = 1'b1;
      default: aux_wr = 1'b1;
    endcase
    cyc(4);
    m1_wr = 1'b0; m2_wr = 1'b0; a_wr = 1'b0; aux_wr = 1'b0;
    cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; bmode = 0; smode = 0; sdata = 0; sclk = 0; load_n = 1; aux_wr = 0;
    fsel_ser = 0; fsel_par = 0; pbus = '0; m1_wr = 0; m2_wr = 0; a_wr = 0;
    hop_wr = 0; dir_pre_n = 0; dir_m = '0; dir_r = '0; dir_a = '0;
    cyc(5);
    rst = 0;
    cyc(4);
    expect_now("R12 reset");

    // direct mode
    bmode = 1; dir_pre_n = 1; dir_m = 9'h1A7; dir_r = 6'h2D; dir_a = 4'h9;
    m1_wr = 1; hop_wr = 1; cyc(4); m1_wr = 0; hop_wr = 0;
    expect_now("R1 direct");
    bmode = 0;

    // serial load of staging word
    smode = 1; fsel_ser = 1; load_n = 0;
    shift_bits(20'hA5C3B, 20);
    m_prim = 20'hA5C3B;
    expect_now("R2 serial staging");
    fsel_ser = 0;
    expect_now("R9 serial active before copy");
    load_n = 1; m_sec = m_prim;
    expect_now("R4 load-enable copy");

    // serial auxiliary
    load_n = 0; aux_wr = 1;
    shift_bits(20'h000C9, 8);
    m_aux = 8'hC9;
    load_n = 1; m_sec = m_prim;
    cyc(4); aux_wr = 0; fsel_ser = 1;
    expect_now("R3 serial aux");

    // clocks with load window closed
    shift_bits(20'h0001F, 5);
    expect_now("R2 shift ignored while load_n high");

    // parallel strobes in serial mode
    pstrobe(1, 8'hFF); pstrobe(2, 8'hFF); pstrobe(3, 8'hFF);
    expect_now("R11 parallel strobes in serial mode");

    // parallel mode
    smode = 0; fsel_par = 1;
    pstrobe(1, 8'h3C); m_prim[19] = 1'b0; m_prim[16:10] = 7'h3C;
    expect_now("R5 m1 write");
    pstrobe(2, 8'h0E); m_prim[9:8] = 2'b11; m_prim[18:17] = 2'b10;
    expect_now("R6 m2 write");
    pstrobe(3, 8'h96); m_prim[7:4] = 4'h9; m_prim[3:0] = 4'h6;
    expect_now("R7 a write");
    pstrobe(4, 8'h5A); m_aux = 8'h5A;
    expect_now("R8 aux write");
    load_n = 0;
    shift_bits(20'hFFFFF, 6);
    load_n = 1;
    expect_now("R11 serial clocks in parallel mode");

    fsel_par = 0;
    expect_now("R9 parallel active select");
    hop_wr = 1; cyc(4); hop_wr = 0; m_sec = m_prim;
    expect_now("R10 hop copy");

    // hop and field write in the same cycle
    pbus = 8'h21; cyc(4);
    hop_wr = 1; a_wr = 1; cyc(4); hop_wr = 0; a_wr = 0;
    m_sec = m_prim; m_prim[7:4] = 4'h2; m_prim[3:0] = 4'h1;
    expect_now("R10 same-cycle hop keeps prior staging");
    fsel_par = 1;
    expect_now("R7 same-cycle write lands in staging");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule